// File: doc/BRIEF.md
# Address Space Decoder with Memory-Mapped Peripherals

This block sits between a 16-bit processor core and its memories and small I/O devices. It splits the 64 KiB byte address space into three regions. The low quarter holds read-only program storage. The second quarter holds peripheral registers. The upper half holds working memory. The block raises a select line for whichever external array the current access targets, and it multiplexes that array's read data back to the core. Accesses in the peripheral quarter are answered by peripherals inside the block.

There are four peripherals. The first is a one-character receive buffer with a pending flag. The second is a one-shot transmit register. The third is a counter of seconds ticks. The fourth is a bank of seven-segment digit registers. The receive buffer and the tick counter empty themselves when the core reads them. On both serial pins a zero byte means "no character". The serial pins therefore have no valid/ready handshake and no back-pressure. A character that arrives before the previous one is read replaces it. A transmitted byte is present on the output for a single cycle, and the receiver must take it in that cycle.

The core interface is plain strobes. Read data is combinational in the cycle the read strobe is high. Side effects of a read, such as clearing a register, take place at the clock edge that ends that cycle.

Top module: `mem_space_hub`

## Requirements
- R1: Any access (read or write strobe high) to 0x0000–0x3FFF raises `rom_sel`, and any access to 0x8000–0xFFFF raises `ram_sel`. Accesses to 0x4000–0x7FFF raise neither. With no strobe, both are low.
- R2: When `cpu_rd` is high, `cpu_rdata` carries `rom_rdata` for the low region and `ram_rdata` for the upper half, in the same cycle. When `cpu_rd` is low, `cpu_rdata` is zero.
- R3: A nonzero `ser_rx` byte is captured into the receive buffer at the clock edge. A newer nonzero byte replaces an unread one. A zero `ser_rx` leaves the buffer unchanged.
- R4: A byte read (`cpu_word`=0) at 0x4100 returns {8'h00, buffer} in the same cycle and clears the buffer at the edge. If a nonzero `ser_rx` byte arrives in that same cycle, the buffer holds the new byte instead.
- R5: `rx_pending` is high exactly when the receive buffer is nonzero.
- R6: A byte write at 0x4102 puts `cpu_wdata[7:0]` on `ser_tx` for exactly the next cycle. In every other cycle `ser_tx` is zero.
- R7: Each clock cycle with `tick_in` high increments the tick counter by one. The counter wraps at its width.
- R8: A word read (`cpu_word`=1) at 0x4000 returns the tick count, zero-extended, and resets the counter. A tick in that same cycle leaves the counter at 1.
- R9: A byte write at 0x4200+i (i = 0..7) loads `cpu_wdata[7:0]` into digit i, which appears on `seg_digits[8*i+7:8*i]` from the next cycle. Digits hold their value otherwise.
- R10: Peripheral-region reads at any other address or access size return zero and have no side effect. Writes there change nothing. This covers a word read of 0x4100, a byte read of 0x4000, and word writes to the transmit or digit addresses.
- R11: After reset, the receive buffer, tick counter, transmit output and all digits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Byte address of the access |
| cpu_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| cpu_word | input | 1 | 1 = word access, 0 = byte access |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 16 | Read data, valid in the cycle of `cpu_rd` |
| rom_sel | output | 1 | Access targets the program storage region |
| ram_sel | output | 1 | Access targets the working memory region |
| rom_rdata | input | 16 | Read data from program storage |
| ram_rdata | input | 16 | Read data from working memory |
| ser_rx | input | 8 | Incoming character, zero = none |
| tick_in | input | 1 | Seconds tick, one count per high cycle |
| ser_tx | output | 8 | Outgoing character, zero = none |
| rx_pending | output | 1 | Receive buffer holds an unread character |
| seg_digits | output | 64 | Eight digit registers, digit i at bits 8i+7:8i |

## Verification
The region decode is probed at both edges of each region boundary, with both access sizes and with no strobe. This separates a decode on the top address bits from one that ignores the strobes. The receive path is driven with single characters, back-to-back overwrites, zero bytes and a character arriving during the clearing read. These cases tell a correct buffer from one that loses the new byte, or that lets a read of the wrong size clear it. The tick counter is read after idle time, after a run of ticks, and during a tick. Digit and transmit writes are paired with near-miss addresses and the wrong access size, so that loose address matching shows up as a changed output.

// File: rtl/mmio_map_pkg.sv
package mmio_map_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    AREA_ROM  = 2'd0,
    AREA_MMIO = 2'd1,
    AREA_RAM  = 2'd2
  } area_e;

  localparam logic [ADDR_W-1:0] TICK_ADDR  = 16'h4000;
  localparam logic [ADDR_W-1:0] RX_ADDR    = 16'h4100;
  localparam logic [ADDR_W-1:0] TX_ADDR    = 16'h4102;
  localparam logic [ADDR_W-1:0] DIGIT_BASE = 16'h4200;

  function automatic area_e area_of(input logic [1:0] top_bits);
    if (top_bits[1])       return AREA_RAM;
    else if (top_bits[0])  return AREA_MMIO;
    else                   return AREA_ROM;
  endfunction
endpackage

// File: rtl/area_decode.sv
module area_decode
  import mmio_map_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] top_bits,
  input  logic       access,
  output logic       rom_sel,
  output logic       mmio_sel,
  output logic       ram_sel
);
  area_e area;

  always_comb begin
    area     = area_of(top_bits);
    rom_sel  = access && (area == AREA_ROM);
    mmio_sel = access && (area == AREA_MMIO);
    ram_sel  = access && (area == AREA_RAM);
  end

  // R1
  area_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access |-> $onehot({rom_sel, mmio_sel, ram_sel}));

  // R1
  area_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !access |-> !(rom_sel || mmio_sel || ram_sel));
endmodule

// File: rtl/rx_holder.sv
module rx_holder #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAR_W-1:0] ser_rx,
  input  logic              rd_clr,
  output logic [CHAR_W-1:0] rx_byte,
  output logic              rx_pending
);
  logic [CHAR_W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 rx_q <= '0;
    else if (ser_rx != '0)      rx_q <= ser_rx;
    else if (rd_clr)            rx_q <= '0;
  end

  assign rx_byte    = rx_q;
  assign rx_pending = |rx_q;

  // R3
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_rx != '0) |=> (rx_q == $past(ser_rx)));

  // R4
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && ser_rx == '0) |=> (rx_q == '0));

  // R3
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && ser_rx == '0) |=> $stable(rx_q));
endmodule

// File: rtl/tick_tally.sv
module tick_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (rd_clr) cnt_q <= CNT_W'(tick_in);
    else if (tick_in) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

  // R8
  tick_read_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && tick_in) |=> (cnt_q == CNT_W'(1)));

  // R8
  tick_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !tick_in) |=> (cnt_q == '0));

  // R7
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && tick_in) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/tx_pulse.sv
module tx_pulse #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_char,
  output logic [CHAR_W-1:0] ser_tx
);
  logic [CHAR_W-1:0] tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     tx_q <= '0;
    else if (wr_en) tx_q <= wr_char;
    else            tx_q <= '0;
  end

  assign ser_tx = tx_q;

  // R6
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (tx_q == '0));

  // R6
  tx_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tx_q == $past(wr_char)));
endmodule

// File: rtl/digit_bank.sv
module digit_bank #(
  parameter int NUM_DIGITS = 8,
  parameter int SEG_W      = 8,
  localparam int IDX_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [SEG_W-1:0]            wr_val,
  output logic [NUM_DIGITS*SEG_W-1:0] seg_digits
);
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    logic [SEG_W-1:0] dig_q;
    logic             hit;

    assign hit = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)   dig_q <= '0;
      else if (hit) dig_q <= wr_val;
    end

    assign seg_digits[i*SEG_W +: SEG_W] = dig_q;

    // R9
    digit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == IDX_W'(i)) |=> $stable(seg_digits[i*SEG_W +: SEG_W]));

    // R9
    digit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(i)) |=> (seg_digits[i*SEG_W +: SEG_W] == $past(wr_val)));
  end
endmodule

// File: rtl/mem_space_hub.sv
module mem_space_hub
  import mmio_map_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int SEG_W      = 8,
  parameter int TICK_W     = 16,
  localparam int DIG_IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic [DATA_W-1:0]           cpu_wdata,
  input  logic                        cpu_word,
  input  logic                        cpu_rd,
  input  logic                        cpu_wr,
  output logic [DATA_W-1:0]           cpu_rdata,
  output logic                        rom_sel,
  output logic                        ram_sel,
  input  logic [DATA_W-1:0]           rom_rdata,
  input  logic [DATA_W-1:0]           ram_rdata,
  input  logic [BYTE_W-1:0]           ser_rx,
  input  logic                        tick_in,
  output logic [BYTE_W-1:0]           ser_tx,
  output logic                        rx_pending,
  output logic [NUM_DIGITS*SEG_W-1:0] seg_digits
);
  logic              mmio_sel;
  logic              rx_rd, tick_rd, tx_wr, dig_wr, dig_in_range;
  logic [ADDR_W-1:0] dig_off;
  logic [BYTE_W-1:0] rx_byte;
  logic [TICK_W-1:0] tick_cnt;
  logic              unused_hi;

  assign unused_hi = ^cpu_wdata[DATA_W-1:BYTE_W];

  area_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .top_bits (cpu_addr[ADDR_W-1:ADDR_W-2]),
    .access   (cpu_rd || cpu_wr),
    .rom_sel  (rom_sel),
    .mmio_sel (mmio_sel),
    .ram_sel  (ram_sel)
  );

  always_comb begin
    dig_off      = cpu_addr - DIGIT_BASE;
    dig_in_range = (cpu_addr >= DIGIT_BASE) && (dig_off < ADDR_W'(NUM_DIGITS));
    rx_rd        = mmio_sel && cpu_rd && !cpu_word && (cpu_addr == RX_ADDR);
    tick_rd      = mmio_sel && cpu_rd &&  cpu_word && (cpu_addr == TICK_ADDR);
    tx_wr        = mmio_sel && cpu_wr && !cpu_word && (cpu_addr == TX_ADDR);
    dig_wr       = mmio_sel && cpu_wr && !cpu_word && dig_in_range;
  end

  rx_holder #(.CHAR_W(BYTE_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_rx     (ser_rx),
    .rd_clr     (rx_rd),
    .rx_byte    (rx_byte),
    .rx_pending (rx_pending)
  );

  tick_tally #(.CNT_W(TICK_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_in (tick_in),
    .rd_clr  (tick_rd),
    .count   (tick_cnt)
  );

  tx_pulse #(.CHAR_W(BYTE_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tx_wr),
    .wr_char (cpu_wdata[BYTE_W-1:0]),
    .ser_tx  (ser_tx)
  );

  digit_bank #(.NUM_DIGITS(NUM_DIGITS), .SEG_W(SEG_W)) u_dig (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (dig_wr),
    .wr_idx     (dig_off[DIG_IDX_W-1:0]),
    .wr_val     (cpu_wdata[SEG_W-1:0]),
    .seg_digits (seg_digits)
  );

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd) begin
      if (rom_sel)      cpu_rdata = rom_rdata;
      else if (ram_sel) cpu_rdata = ram_rdata;
      else if (rx_rd)   cpu_rdata = DATA_W'(rx_byte);
      else if (tick_rd) cpu_rdata = DATA_W'(tick_cnt);
    end
  end

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && mmio_sel && !rx_rd && !tick_rd) |-> (cpu_rdata == '0));

  // R2
  no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |-> (cpu_rdata == '0));

  // R5
  pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd |-> (rx_pending == (cpu_rdata != '0)));
endmodule

// File: tb/mem_space_hub_test.sv
module mem_space_hub_test;
  localparam int PERIOD = 10;

  typedef struct {
    int          kind;
    int          idx;
    logic [15:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_word = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [15:0] cpu_rdata;
  logic        rom_sel, ram_sel;
  logic [15:0] rom_rdata = 16'hA5A5, ram_rdata = 16'h5A5A;
  logic [7:0]  ser_rx = '0;
  logic        tick_in = 1'b0;
  logic [7:0]  ser_tx;
  logic        rx_pending;
  logic [63:0] seg_digits;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  item_t sb[$];

  always #(PERIOD/2) clk = ~clk;

  mem_space_hub uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_word(cpu_word), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
    .ser_rx(ser_rx), .tick_in(tick_in), .ser_tx(ser_tx), .rx_pending(rx_pending),
    .seg_digits(seg_digits)
  );

  // kinds: 0 rdata, 1 ser_tx, 2 rx_pending, 3 digit idx, 4 rom_sel, 5 ram_sel
  function automatic logic [15:0] observe(int kind, int idx);
    case (kind)
      0: return cpu_rdata;
      1: return {8'h00, ser_tx};
      2: return {15'h0, rx_pending};
      3: return {8'h00, seg_digits[idx*8 +: 8]};
      4: return {15'h0, rom_sel};
      default: return {15'h0, ram_sel};
    endcase
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it  = sb.pop_front();
        got = observe(it.kind, it.idx);
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s kind %0d idx %0d: got %h expected %h", it.req, it.kind, it.idx, got, it.exp);
        end
      end
    end
  end

  task automatic want(int kind, int idx, logic [15:0] v, string req);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = v; it.req = req;
    sb.push_back(it);
  endtask

  task automatic step(logic rd, logic wr, logic word, logic [15:0] a,
                      logic [15:0] wd, logic [7:0] rx, logic tk);
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_word = word; cpu_addr = a;
    cpu_wdata = wd; ser_rx = rx; tick_in = tk;
  endtask

  task automatic idle(logic [7:0] rx = 8'h00, logic tk = 1'b0);
    step(1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, rx, tk);
  endtask

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    idle();
    want(2, 0, 16'h0, "R11"); want(1, 0, 16'h0, "R11");
    want(3, 0, 16'h0, "R11"); want(3, 7, 16'h0, "R11");
    step(1, 0, 1, 16'h4000, 0, 0, 0);
    want(0, 0, 16'h0, "R11"); want(4, 0, 16'h0, "R1"); want(5, 0, 16'h0, "R1");
    step(1, 0, 1, 16'h3FFF, 0, 0, 0);
    want(4, 0, 16'h1, "R1"); want(5, 0, 16'h0, "R1"); want(0, 0, 16'hA5A5, "R2");
    step(1, 0, 0, 16'h0000, 0, 0, 0);
    want(4, 0, 16'h1, "R1");
    step(1, 0, 1, 16'h8000, 0, 0, 0);
    want(5, 0, 16'h1, "R1"); want(4, 0, 16'h0, "R1"); want(0, 0, 16'h5A5A, "R2");
    step(0, 1, 1, 16'hFFFF, 0, 0, 0);
    want(5, 0, 16'h1, "R1"); want(4, 0, 16'h0, "R1");
    step(0, 1, 1, 16'h7FFF, 0, 0, 0);
    want(5, 0, 16'h0, "R1"); want(4, 0, 16'h0, "R1");
    step(1, 0, 0, 16'h7FFF, 0, 0, 0);
    want(0, 0, 16'h0, "R10");
    step(0, 0, 1, 16'h0000, 0, 0, 0);
    want(0, 0, 16'h0, "R2"); want(4, 0, 16'h0, "R1");

    // receive path
    idle(8'h41);
    idle();
    want(2, 0, 16'h1, "R5");
    step(1, 0, 0, 16'h4100, 0, 0, 0);
    want(0, 0, 16'h0041, "R4");
    idle();
    want(2, 0, 16'h0, "R5");
    step(1, 0, 0, 16'h4100, 0, 0, 0);
    want(0, 0, 16'h0, "R4");
    idle(8'h41);
    idle(8'h42);
    step(1, 0, 0, 16'h4100, 0, 0, 0);
    want(0, 0, 16'h0042, "R3");
    idle(8'h43);
    idle();
    step(1, 0, 1, 16'h4100, 0, 0, 0);
    want(0, 0, 16'h0, "R10"); want(0, 0, 16'h0, "R3");
    idle();
    want(2, 0, 16'h1, "R10");
    step(1, 0, 0, 16'h4100, 0, 8'h44, 0);
    want(0, 0, 16'h0043, "R3");
    idle();
    want(2, 0, 16'h1, "R4");
    step(1, 0, 0, 16'h4100, 0, 0, 0);
    want(0, 0, 16'h0044, "R4");
    idle();
    want(2, 0, 16'h0, "R5");

    // transmit path
    step(0, 1, 0, 16'h4102, 16'h1255, 0, 0);
    want(1, 0, 16'h0, "R6");
    idle();
    want(1, 0, 16'h0055, "R6");
    idle();
    want(1, 0, 16'h0, "R6");
    step(0, 1, 1, 16'h4102, 16'h0066, 0, 0);
    idle();
    want(1, 0, 16'h0, "R10");
    step(0, 1, 0, 16'h4103, 16'h0077, 0, 0);
    idle();
    want(1, 0, 16'h0, "R10");

    // tick counter
    idle(8'h00, 1'b1);
    idle(8'h00, 1'b1);
    idle(8'h00, 1'b1);
    step(1, 0, 1, 16'h4000, 0, 0, 0);
    want(0, 0, 16'd3, "R7");
    step(1, 0, 1, 16'h4000, 0, 0, 0);
    want(0, 0, 16'd0, "R8");
    idle(8'h00, 1'b1);
    idle(8'h00, 1'b1);
    step(1, 0, 1, 16'h4000, 0, 0, 1);
    want(0, 0, 16'd2, "R8");
    step(1, 0, 1, 16'h4000, 0, 0, 0);
    want(0, 0, 16'd1, "R8");
    idle(8'h00, 1'b1);
    step(1, 0, 0, 16'h4000, 0, 0, 0);
    want(0, 0, 16'd0, "R10");
    step(1, 0, 1, 16'h4000, 0, 0, 0);
    want(0, 0, 16'd1, "R10");

    // digits
    step(0, 1, 0, 16'h4200, 16'h003F, 0, 0);
    step(0, 1, 0, 16'h4207, 16'hAA06, 0, 0);
    want(3, 0, 16'h003F, "R9");
    idle();
    want(3, 0, 16'h003F, "R9"); want(3, 7, 16'h0006, "R9");
    step(0, 1, 0, 16'h4208, 16'h0011, 0, 0);
    step(0, 1, 1, 16'h4201, 16'h0022, 0, 0);
    want(3, 0, 16'h003F, "R10"); want(3, 7, 16'h0006, "R10");
    idle();
    want(3, 1, 16'h0, "R10"); want(3, 0, 16'h003F, "R10"); want(1, 0, 16'h0, "R10");
    step(1, 0, 0, 16'h4200, 0, 0, 0);
    want(0, 0, 16'h0, "R10");
    idle();

    @(negedge clk);
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule